// File: doc/BRIEF.md
# Almost-Flag Threshold Programmer

This block keeps the two threshold values that a FIFO's flag logic compares its fill level against: the distance from the empty boundary at which an almost-empty warning starts, and the distance from the full boundary at which an almost-full warning starts. A single select input, sampled while master reset is held, fixes both the reset defaults and the loading method:

- **Word-wide loading:** the defaults are 127, and the thresholds are written a word at a time over the data bus.
- **Bit-serial loading:** the defaults are 1023, and the thresholds are shifted in one bit at a time on a serial input.

Both loading methods run on the write clock. Readback is always word-wide on the output bus and runs on the read clock, whichever loading method is in force.

Each threshold is wider than one bus word, so word access walks a fixed four-step sequence:

1. almost-empty low word
2. almost-empty high word
3. almost-full low word
4. almost-full high word

After the fourth step the sequence wraps to the first. The write side and the read side each keep their own position in this sequence. A partial reset rewinds both positions and the serial bit count, and it leaves the threshold values and the chosen loading method untouched. While the load-select input is active, write and read enables are steered to threshold access instead of to the FIFO array, so the block also produces the gated array-write and array-read strobes.

Top module: `almost_ofs_prog`

## Requirements
- R1: With `mrst` high and `ld` low on a write-clock edge, both thresholds become 127 and `ser_mode` becomes 0 (word-wide loading).
- R2: With `mrst` high and `ld` high on a write-clock edge, both thresholds become 1023 and `ser_mode` becomes 1 (bit-serial loading).
- R3: With `ser_mode`=0, each write-clock edge with `wen`=1 and `ld`=1 (and no reset) writes `d` into the word at the write position. The position then advances through the sequence 0 to 3 and wraps to 0. The words are defined as follows:
  - Position 0 writes `ae_ofs[8:0]`.
  - Position 1 writes `ae_ofs[13:9]` from `d[4:0]`.
  - Position 2 writes `af_ofs[8:0]`.
  - Position 3 writes `af_ofs[13:9]` from `d[4:0]`.
- R4: With `ser_mode`=1, each write-clock edge with `sen`=1 and `ld`=1 stores `si` into the next threshold bit. The first 14 shifts fill `ae_ofs` from bit 0 upward, and the next 14 shifts fill `af_ofs` from bit 0 upward.
- R5: After 28 serial bits have been stored, further shifts change neither threshold until the next master or partial reset.
- R6: The loading method not selected has no effect. Word writes do nothing while `ser_mode`=1, and serial shifts do nothing while `ser_mode`=0; neither case changes a threshold or advances a position.
- R7: Each read-clock edge with `ren`=1 and `ld`=1 (and no reset) loads `q` with the word at the read position and sets `q_vld` to 1 for one cycle. The read position then advances in the same order as in R3. Each high word is returned in `q[4:0]` with `q[8:5]`=0. Readback works in both loading modes. Otherwise `q_vld` is 0 and `q` holds its last value.
- R8: A partial reset (`prst`=1) rewinds the write position, the read position and the serial count to their starting points. It leaves `ae_ofs`, `af_ofs` and `ser_mode` unchanged.
- R9: `fifo_wr_en` equals `wen` AND NOT `ld`, and `fifo_rd_en` equals `ren` AND NOT `ld`.
- R10: A readback on the same edge as a word write to the same word returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ld | input | 1 | Load select; also picks the defaults and loading method during master reset |
| wen | input | 1 | Write enable |
| sen | input | 1 | Serial shift enable |
| si | input | 1 | Serial data bit |
| d | input | 9 | Write data bus |
| ren | input | 1 | Read enable |
| ae_ofs | output | 14 | Almost-empty threshold |
| af_ofs | output | 14 | Almost-full threshold |
| ser_mode | output | 1 | 1 selects bit-serial loading, 0 selects word-wide loading |
| q | output | 9 | Readback word |
| q_vld | output | 1 | Readback word valid this cycle |
| fifo_wr_en | output | 1 | Gated write strobe for the FIFO array |
| fifo_rd_en | output | 1 | Gated read strobe for the FIFO array |

## Verification
The write path and the readback path can both act on the same clock edge, and the case that matters is both of them pointing at the same threshold word. The bench ties both clocks to one source and rewinds both positions with a partial reset. It then issues a word write and a readback together, so that on every edge both target the same word. It expects each returned word to carry the value from before that edge and the stored value to take the new word. A long pseudo-random phase mixes writes, shifts, reads and partial resets in both modes, and a behavioural model is compared against every output on every cycle.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int NWORDS = 4;

  typedef enum logic [1:0] {
    W_AE_LO = 2'd0,
    W_AE_HI = 2'd1,
    W_AF_LO = 2'd2,
    W_AF_HI = 2'd3
  } ofs_word_e;
endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr #(
  parameter int NW = 4,
  localparam int PW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          step_o
);
  localparam logic [PW-1:0] LAST = PW'(NW - 1);

  function automatic logic [PW-1:0] next_pos(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign step_o = adv && !clr;

  always_ff @(posedge clk) begin
    if (clr)         ptr <= '0;
    else if (step_o) ptr <= next_pos(ptr);
  end

  // R3 / R7: a granted step moves exactly one position, wrapping after the last
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (clr)
    step_o |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFS_W    = 14,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023,
  localparam int CW = $clog2(2 * OFS_W + 1)
) (
  input  logic              wclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              ld,
  input  logic              wen,
  input  logic              sen,
  input  logic              si,
  input  logic [DATA_W-1:0] d,
  input  ofs_word_e         wsel,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              ser_mode,
  output logic              par_fire,
  output logic              sh_fire,
  output logic              sh_done
);
  localparam logic [OFS_W-1:0] DEF_P   = OFS_W'(DFLT_PAR);
  localparam logic [OFS_W-1:0] DEF_S   = OFS_W'(DFLT_SER);
  localparam logic [CW-1:0]    SH_END  = CW'(2 * OFS_W);
  localparam logic [CW-1:0]    SH_HALF = CW'(OFS_W);

  logic [CW-1:0] scnt;

  // replace the low word, keep the high part
  function automatic logic [OFS_W-1:0] put_lo(input logic [OFS_W-1:0] v,
                                               input logic [DATA_W-1:0] w);
    logic [OFS_W-1:0] r;
    r = v;
    r[DATA_W-1:0] = w;
    return r;
  endfunction

  // replace the high part from the low bits of the word
  function automatic logic [OFS_W-1:0] put_hi(input logic [OFS_W-1:0] v,
                                               input logic [DATA_W-1:0] w);
    logic [2*DATA_W-1:0] cat;
    cat = {w, v[DATA_W-1:0]};
    return cat[OFS_W-1:0];
  endfunction

  function automatic logic [OFS_W-1:0] put_bit(input logic [OFS_W-1:0] v,
                                                input logic [CW-1:0] idx,
                                                input logic b);
    logic [OFS_W-1:0] r;
    r = v;
    for (int i = 0; i < OFS_W; i++)
      if (CW'(i) == idx) r[i] = b;
    return r;
  endfunction

  assign sh_done  = (scnt == SH_END);
  assign par_fire = !mrst && !prst && !ser_mode && wen && ld;
  assign sh_fire  = !mrst && !prst && ser_mode && sen && ld && !sh_done;

  always_ff @(posedge wclk) begin
    if (mrst) begin
      ser_mode <= ld;
      ae_ofs   <= ld ? DEF_S : DEF_P;
      af_ofs   <= ld ? DEF_S : DEF_P;
      scnt     <= '0;
    end else if (prst) begin
      scnt <= '0;
    end else begin
      if (par_fire) begin
        unique case (wsel)
          W_AE_LO: ae_ofs <= put_lo(ae_ofs, d);
          W_AE_HI: ae_ofs <= put_hi(ae_ofs, d);
          W_AF_LO: af_ofs <= put_lo(af_ofs, d);
          W_AF_HI: af_ofs <= put_hi(af_ofs, d);
        endcase
      end
      if (sh_fire) begin
        if (scnt < SH_HALF) ae_ofs <= put_bit(ae_ofs, scnt, si);
        else                af_ofs <= put_bit(af_ofs, scnt - SH_HALF, si);
        scnt <= scnt + 1'b1;
      end
    end
  end

  // R6: thresholds move only on a granted word write or serial shift
  assert_hold_idle_R6: assert property (@(posedge wclk) disable iff (mrst)
    (!par_fire && !sh_fire) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  // R5: once full, the serial count stays full until a reset
  assert_shift_stop_R5: assert property (@(posedge wclk) disable iff (mrst || prst)
    sh_done |=> sh_done);

  // R8: partial reset keeps values and mode
  assert_prst_keep_R8: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(ser_mode)));
endmodule

// File: rtl/ofs_rd_mux.sv
module ofs_rd_mux
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 14
) (
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              ld,
  input  logic              ren,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  input  ofs_word_e         rsel,
  output logic              rd_fire,
  output logic [DATA_W-1:0] q,
  output logic              q_vld
);
  localparam int PADW = 2 * DATA_W - OFS_W;

  function automatic logic [DATA_W-1:0] hi_word(input logic [OFS_W-1:0] v);
    return {{PADW{1'b0}}, v[OFS_W-1:DATA_W]};
  endfunction

  function automatic logic [DATA_W-1:0] pick(input ofs_word_e s,
                                              input logic [OFS_W-1:0] a,
                                              input logic [OFS_W-1:0] f);
    unique case (s)
      W_AE_LO: return a[DATA_W-1:0];
      W_AE_HI: return hi_word(a);
      W_AF_LO: return f[DATA_W-1:0];
      default: return hi_word(f);
    endcase
  endfunction

  assign rd_fire = !mrst && !prst && ren && ld;

  always_ff @(posedge rclk) begin
    if (mrst) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q_vld <= rd_fire;
      if (rd_fire) q <= pick(rsel, ae_ofs, af_ofs);
    end
  end

  // R7: every granted readback raises valid on the following cycle
  assert_rd_valid_R7: assert property (@(posedge rclk) disable iff (mrst)
    rd_fire |=> q_vld);

  // R7: with no granted readback the output word holds
  assert_rd_hold_R7: assert property (@(posedge rclk) disable iff (mrst)
    !rd_fire |=> (!q_vld && $stable(q)));
endmodule

// File: rtl/almost_ofs_prog.sv
module almost_ofs_prog
  import ofs_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFS_W    = 14,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              ld,
  input  logic              wen,
  input  logic              sen,
  input  logic              si,
  input  logic [DATA_W-1:0] d,
  input  logic              ren,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              ser_mode,
  output logic [DATA_W-1:0] q,
  output logic              q_vld,
  output logic              fifo_wr_en,
  output logic              fifo_rd_en
);
  localparam int PW = $clog2(NWORDS);

  logic [PW-1:0] wpos, rpos;
  logic          par_fire, sh_fire, sh_done, rd_fire;
  logic          wstep, rstep;
  logic          seq_clr;

  assign seq_clr    = mrst || prst;
  assign fifo_wr_en = wen && !ld;
  assign fifo_rd_en = ren && !ld;

  ofs_seq_ptr #(.NW(NWORDS)) u_wseq (
    .clk(wclk), .clr(seq_clr), .adv(par_fire), .ptr(wpos), .step_o(wstep)
  );

  ofs_seq_ptr #(.NW(NWORDS)) u_rseq (
    .clk(rclk), .clr(seq_clr), .adv(rd_fire), .ptr(rpos), .step_o(rstep)
  );

  ofs_store #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .DFLT_PAR(DFLT_PAR), .DFLT_SER(DFLT_SER)
  ) u_store (
    .wclk(wclk), .mrst(mrst), .prst(prst), .ld(ld), .wen(wen), .sen(sen),
    .si(si), .d(d), .wsel(ofs_word_e'(wpos)),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ser_mode(ser_mode),
    .par_fire(par_fire), .sh_fire(sh_fire), .sh_done(sh_done)
  );

  ofs_rd_mux #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .rclk(rclk), .mrst(mrst), .prst(prst), .ld(ld), .ren(ren),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rsel(ofs_word_e'(rpos)),
    .rd_fire(rd_fire), .q(q), .q_vld(q_vld)
  );

  // R6: the two loading methods never act together
  assert_one_method_R6: assert property (@(posedge wclk) disable iff (mrst)
    !(wstep && sh_fire));

  // R5: a finished serial load grants no further shift
  assert_no_late_shift_R5: assert property (@(posedge wclk) disable iff (mrst)
    sh_done |-> !sh_fire);

  // R7: read position only moves with a readback
  assert_rstep_R7: assert property (@(posedge rclk) disable iff (mrst)
    rstep |=> q_vld);
endmodule

// File: tb/almost_ofs_prog_tb_top.sv
module almost_ofs_prog_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 9;
  localparam int OW = 14;
  localparam int LOW_SPAN = 512;
  localparam int HI_SPAN = 32;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, ld = 1'b0, wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
  logic [DW-1:0] d = '0;
  logic [OW-1:0] ae_ofs, af_ofs;
  logic [DW-1:0] q;
  logic ser_mode, q_vld, fifo_wr_en, fifo_rd_en;

  int total = 0;
  int bad = 0;
  int m_ae = 0, m_af = 0, m_ser = 0, m_wp = 0, m_rp = 0, m_sc = 0, m_q = 0, m_qv = 0;
  int seed = 12345;

  always #(CLK_P / 2) clk = ~clk;

  almost_ofs_prog dut_i (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .ld(ld), .wen(wen),
    .sen(sen), .si(si), .d(d), .ren(ren), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .ser_mode(ser_mode), .q(q), .q_vld(q_vld),
    .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en)
  );

  function automatic int word_of(int pos);
    case (pos)
      0: return m_ae % LOW_SPAN;
      1: return m_ae / LOW_SPAN;
      2: return m_af % LOW_SPAN;
      default: return m_af / LOW_SPAN;
    endcase
  endfunction

  function automatic int with_bit(int v, int k, int b);
    int p = 2 ** k;
    return v - ((v / p) % 2) * p + b * p;
  endfunction

  task automatic model_edge();
    int dv = int'(d);
    if (mrst) begin
      m_ser = ld; m_ae = ld ? 1023 : 127; m_af = m_ae;
      m_wp = 0; m_rp = 0; m_sc = 0; m_q = 0; m_qv = 0;
    end else if (prst) begin
      m_wp = 0; m_rp = 0; m_sc = 0; m_qv = 0;
    end else begin
      if (ren && ld) begin
        m_q = word_of(m_rp); m_qv = 1; m_rp = (m_rp + 1) % 4;
      end else m_qv = 0;
      if (!m_ser && wen && ld) begin
        case (m_wp)
          0: m_ae = (m_ae / LOW_SPAN) * LOW_SPAN + dv % LOW_SPAN;
          1: m_ae = (dv % HI_SPAN) * LOW_SPAN + m_ae % LOW_SPAN;
          2: m_af = (m_af / LOW_SPAN) * LOW_SPAN + dv % LOW_SPAN;
          default: m_af = (dv % HI_SPAN) * LOW_SPAN + m_af % LOW_SPAN;
        endcase
        m_wp = (m_wp + 1) % 4;
      end
      if (m_ser && sen && ld && m_sc < 2 * OW) begin
        if (m_sc < OW) m_ae = with_bit(m_ae, m_sc, int'(si));
        else           m_af = with_bit(m_af, m_sc - OW, int'(si));
        m_sc++;
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "ae_ofs", int'(ae_ofs), m_ae);
    chk(tag, "af_ofs", int'(af_ofs), m_af);
    chk(tag, "ser_mode", int'(ser_mode), m_ser);
    chk(tag, "q_vld", int'(q_vld), m_qv);
    chk(tag, "q", int'(q), m_q);
    chk("R9", "fifo_wr_en", int'(fifo_wr_en), int'(wen && !ld));
    chk("R9", "fifo_rd_en", int'(fifo_rd_en), int'(ren && !ld));
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ld = 0; wen = 0; sen = 0; ren = 0; si = 0; d = '0;
  endtask

  function automatic int rnd(int n);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fff_ffff) % n;
  endfunction

  task automatic mix(string tag, int n);
    for (int i = 0; i < n; i++) begin
      idle();
      ld = rnd(4) != 0; wen = rnd(2) != 0; sen = rnd(2) != 0; ren = rnd(2) != 0;
      si = rnd(2) != 0; d = DW'(rnd(LOW_SPAN)); prst = rnd(24) == 0;
      tick(tag);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: master reset with ld low
    mrst = 1; ld = 0; tick("R1"); tick("R1");
    idle(); tick("R1");
    chk("R1", "ae default", int'(ae_ofs), 127);
    chk("R1", "mode", int'(ser_mode), 0);

    // R3: four words in order, then wrap
    ld = 1; wen = 1;
    d = 9'h1A5; tick("R3"); d = 9'h013; tick("R3");
    d = 9'h0F0; tick("R3"); d = 9'h1E7; tick("R3");
    chk("R3", "ae after words", int'(ae_ofs), 19 * 512 + 9'h1A5);
    chk("R3", "af after words", int'(af_ofs), 7 * 512 + 9'h0F0);
    d = 9'h055; tick("R3");
    chk("R3", "wrap to ae low", int'(ae_ofs) % 512, 9'h055);

    // R9: wen without ld goes to the array only
    idle(); wen = 1; d = 9'h1FF; tick("R9"); tick("R9");

    // R6: serial shifts ignored in word mode
    idle(); ld = 1; sen = 1; si = 1; tick("R6"); tick("R6"); tick("R6");

    // R7: readback of all four words and wrap
    idle(); ld = 1; ren = 1;
    for (int i = 0; i < 5; i++) tick("R7");
    idle(); tick("R7"); tick("R7");

    // R10: collision of write and read on the same word
    idle(); prst = 1; tick("R8");
    idle(); ld = 1; wen = 1; ren = 1;
    for (int i = 0; i < 6; i++) begin d = DW'(37 * i + 5); tick("R10"); end

    // R8: partial reset keeps values, rewinds positions
    idle(); prst = 1; ld = 1; wen = 1; ren = 1; tick("R8");
    idle(); ld = 1; ren = 1; tick("R8"); tick("R8");

    // R9: ren without ld
    idle(); ren = 1; tick("R9");

    mix("R3", 300);

    // R2: master reset with ld high
    idle(); mrst = 1; ld = 1; tick("R2");
    idle(); tick("R2");
    chk("R2", "ae default", int'(ae_ofs), 1023);
    chk("R2", "mode", int'(ser_mode), 1);

    // R4: shift 28 bits
    idle(); ld = 1; sen = 1;
    for (int i = 0; i < 2 * OW; i++) begin si = ((i % 3) == 0) ^ (i >= OW); tick("R4"); end
    // R5: further shifts ignored
    for (int i = 0; i < 4; i++) begin si = i[0]; tick("R5"); end

    // R6: word writes ignored in serial mode
    idle(); ld = 1; wen = 1; d = 9'h0AA; tick("R6"); tick("R6");

    // R7: readback in serial mode
    idle(); prst = 1; tick("R8");
    idle(); ld = 1; ren = 1;
    for (int i = 0; i < 4; i++) tick("R7");

    // R8: partial reset mid-shift restarts at ae bit 0
    idle(); ld = 1; sen = 1; si = 0;
    for (int i = 0; i < 5; i++) tick("R4");
    idle(); prst = 1; tick("R8");
    idle(); ld = 1; sen = 1; si = 1;
    for (int i = 0; i < 3; i++) tick("R8");

    mix("R4", 300);

    idle(); tick("R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule